// File: doc/BRIEF.md
# Four-Line Serial Multiplexer Control and Transmit Scanner

This block holds the control/status word and the transmit side of a four-line serial multiplexer that sits on a simple register bus. A periodic `tick` strobe drives a round-robin scanner. The scanner walks a two-bit line pointer over the per-line transmit enable bits. When it finds an enabled line, it raises transmit-ready and writes that line's number into the status word. Software then writes a data byte, and the block emits that byte on a (line, byte) strobe. On ticks where the scanner does not raise transmit-ready, the block instead flags receive-done from the non-empty status of an external receive queue.

The register window has four word slots, chosen by address bits [4:3]. Slot 0 is control/status. Slot 1 is receive buffer read and line parameter write. Slot 2 is the transmit enable mask. Slot 3 is modem status read and transmit data write. After a receive buffer read or a transmit data write, a short hold-off suspends tick processing. This gives software time to service the line. A single level-sensitive interrupt output combines both event sources. Bit serialisation and the receive queue storage live outside this block.

Top module: `sio_tx_scan`

## Requirements
- R1: After reset, a control read returns 0x8020: transmit-ready (bit 15) and scan enable (bit 5) set, all else 0. The enable mask reads 0, and `irq` is 0.
- R2: A control write (slot 0) updates only transmit interrupt enable (bit 14), receive interrupt enable (bit 6), scan enable (bit 5), clear (bit 4) and maintenance (bit 3). The clear bit always reads back 0. Writing scan enable as 0 also clears transmit-ready and receive-done (bit 7).
- R3: A tick runs a scan when it is not held off and, after any same-cycle access, scan enable is 1 and transmit-ready is 0. The scan tests lines pointer+1, +2, +3, +4 (mod 4) against mask bits [3:0] and stops at the first enabled line. On a hit, transmit-ready is set, the line number goes into control bits [9:8], and the pointer moves to that line. On a miss, the pointer stays where it was.
- R4: Every tick that is not held off first clears receive-done. If that tick does not set transmit-ready, receive-done then becomes (queue non-empty AND scan enable).
- R5: A tick that sets transmit-ready leaves receive-done at 0 even when the queue is non-empty.
- R6: A write to slot 2 stores mask bits [3:0], which read back zero-extended, and clears transmit-ready.
- R7: A write to slot 3 clears transmit-ready. One cycle later, `tx_valid` pulses with `tx_byte` = write data [7:0] and `tx_line` = control bits [9:8] as they were before the write.
- R8: A read of slot 1 with the queue non-empty returns bit 15 = 1, bits [9:8] = queue line and bits [7:0] = queue character, and pulses `rxq_pop` in the same cycle. With the queue empty it returns 0 and does not pop. Either way it clears receive-done.
- R9: A slot 1 read or a slot 3 write loads a hold-off count of 4, and a tick in the same cycle already uses up one of the 4. A tick that meets a non-zero count only decrements it: no scan, and no change to receive-done.
- R10: `irq` equals (transmit-ready AND transmit interrupt enable) OR (receive-done AND receive interrupt enable).
- R11: A read of slot 3 returns `modem_stat` with bits [11:8] forced to 1 (data-set-ready and carrier detect for lines 2 and 3).
- R12: A write to slot 1 stores the full word on `line_param`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| tick | input | 1 | Scan/evaluate strobe |
| bus_sel | input | 1 | Register access this cycle |
| bus_wr | input | 1 | 1 = write, 0 = read |
| bus_addr | input | 5 | Byte address; bits [4:3] select the slot |
| bus_wdata | input | 16 | Write data |
| bus_rdata | output | 16 | Read data, valid in the access cycle |
| rxq_nonempty | input | 1 | Receive queue holds an entry |
| rxq_char | input | 8 | Character at queue head |
| rxq_line | input | 2 | Line number at queue head |
| rxq_pop | output | 1 | Remove queue head |
| modem_stat | input | 16 | Raw modem status |
| line_param | output | 16 | Last line parameter word |
| tx_valid | output | 1 | Transmit byte strobe |
| tx_line | output | 2 | Line of the transmit byte |
| tx_byte | output | 8 | Transmit byte |
| irq | output | 1 | Level interrupt |

## Verification
The collision that matters is a bus access landing in the same cycle as a tick. For example, a mask write or a scan-enable change meets a scan, or a receive read or data write meets a tick that must already count against the hold-off. The random phase asserts `tick` on about a third of cycles while issuing accesses on most cycles, so these overlaps occur by the hundreds. A bench model applies the access first and then the tick, which is the order the requirements define. Every read, strobe and interrupt level is judged against that model, and directed steps pin down the scan-versus-receive priority and the hold-off.

// File: rtl/sio_pkg.sv
package sio_pkg;
  localparam int REG_W     = 16;
  localparam int CHAR_W    = 8;
  localparam int OFS_LSB   = 3;

  localparam int B_TRDY    = 15;
  localparam int B_TXIE    = 14;
  localparam int B_LINE_LO = 8;
  localparam int B_RDONE   = 7;
  localparam int B_RXIE    = 6;
  localparam int B_SCAN    = 5;
  localparam int B_CLR     = 4;
  localparam int B_MAINT   = 3;
  localparam int B_DVAL    = 15;

  localparam logic [REG_W-1:0] MDM_FORCE = 16'h0F00;

  typedef enum logic [1:0] {
    SLOT_CTL = 2'd0,
    SLOT_RXB = 2'd1,
    SLOT_TXM = 2'd2,
    SLOT_MDM = 2'd3
  } slot_e;

  typedef struct packed {
    logic trdy;
    logic txie;
    logic rdone;
    logic rxie;
    logic scan;
    logic clr;
    logic maint;
  } ctl_t;
endpackage

// File: rtl/sio_line_pick.sv
module sio_line_pick #(
  parameter int NLINES = 4,
  localparam int LW = $clog2(NLINES)
) (
  input  logic [LW-1:0]     ptr,
  input  logic [NLINES-1:0] en,
  output logic              found,
  output logic [LW-1:0]     pick
);
  logic [LW-1:0] cand;

  // nearest enabled line after ptr wins; the loop runs far to near
  always_comb begin
    found = 1'b0;
    pick  = ptr;
    cand  = ptr;
    for (int k = NLINES; k >= 1; k--) begin
      cand = LW'((int'(ptr) + k) % NLINES);
      if (en[cand]) begin
        found = 1'b1;
        pick  = cand;
      end
    end
  end
endmodule

// File: rtl/sio_holdoff.sv
module sio_holdoff #(
  parameter int HOLD_TICKS = 4,
  localparam int CW = $clog2(HOLD_TICKS + 1)
) (
  input  logic clk,
  input  logic rst_n,
  input  logic load,
  input  logic tick,
  output logic go,
  output logic busy
);
  logic [CW-1:0] cnt_q, cnt_eff, cnt_nxt;
  logic          cnt_en;

  always_comb begin
    cnt_eff = load ? CW'(HOLD_TICKS) : cnt_q;
    go      = tick && (cnt_eff == '0);
    cnt_nxt = (tick && (cnt_eff != '0)) ? cnt_eff - 1'b1 : cnt_eff;
    cnt_en  = load | tick;
  end

  assign busy = (cnt_q != '0);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      cnt_q <= '0;
    else if (cnt_en) cnt_q <= cnt_nxt;
  end
endmodule

// File: rtl/sio_rd_mux.sv
module sio_rd_mux
  import sio_pkg::*;
#(
  parameter int NLINES = 4,
  localparam int LW = $clog2(NLINES)
) (
  input  logic [1:0]        slot,
  input  logic [REG_W-1:0]  ctl_word,
  input  logic [NLINES-1:0] tx_mask,
  input  logic              rxq_nonempty,
  input  logic [CHAR_W-1:0] rxq_char,
  input  logic [LW-1:0]     rxq_line,
  input  logic [REG_W-1:0]  modem_stat,
  output logic [REG_W-1:0]  rdata
);
  logic [REG_W-1:0] rxb_word;

  always_comb begin
    rxb_word = '0;
    if (rxq_nonempty) begin
      rxb_word[B_DVAL]            = 1'b1;
      rxb_word[B_LINE_LO +: LW]   = rxq_line;
      rxb_word[CHAR_W-1:0]        = rxq_char;
    end
  end

  always_comb begin
    unique case (slot_e'(slot))
      SLOT_CTL: rdata = ctl_word;
      SLOT_RXB: rdata = rxb_word;
      SLOT_TXM: rdata = REG_W'(tx_mask);
      SLOT_MDM: rdata = modem_stat | MDM_FORCE;
      default:  rdata = '0;
    endcase
  end
endmodule

// File: rtl/sio_tx_scan.sv
module sio_tx_scan
  import sio_pkg::*;
#(
  parameter int NLINES     = 4,
  parameter int HOLD_TICKS = 4,
  parameter int AW         = 5
) (
  input  logic                       clk,
  input  logic                       rst_n,
  input  logic                       tick,
  input  logic                       bus_sel,
  input  logic                       bus_wr,
  input  logic [AW-1:0]              bus_addr,
  input  logic [15:0]                bus_wdata,
  output logic [15:0]                bus_rdata,
  input  logic                       rxq_nonempty,
  input  logic [7:0]                 rxq_char,
  input  logic [$clog2(NLINES)-1:0]  rxq_line,
  output logic                       rxq_pop,
  input  logic [15:0]                modem_stat,
  output logic [15:0]                line_param,
  output logic                       tx_valid,
  output logic [$clog2(NLINES)-1:0]  tx_line,
  output logic [7:0]                 tx_byte,
  output logic                       irq
);
  localparam int LW = $clog2(NLINES);

  // reset: asserted asynchronously, released on a clock edge
  logic rst_s1, rst_sync_n;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rst_s1     <= 1'b0;
      rst_sync_n <= 1'b0;
    end else begin
      rst_s1     <= 1'b1;
      rst_sync_n <= rst_s1;
    end
  end

  // access decode
  logic [1:0] slot;
  logic wr_ctl, wr_lpr, wr_txm, wr_tdr, rd_rxb;
  assign slot   = bus_addr[OFS_LSB+1:OFS_LSB];
  assign wr_ctl = bus_sel &  bus_wr & (slot == SLOT_CTL);
  assign wr_lpr = bus_sel &  bus_wr & (slot == SLOT_RXB);
  assign wr_txm = bus_sel &  bus_wr & (slot == SLOT_TXM);
  assign wr_tdr = bus_sel &  bus_wr & (slot == SLOT_MDM);
  assign rd_rxb = bus_sel & ~bus_wr & (slot == SLOT_RXB);

  // state
  ctl_t              ctl_q, ctl_n;
  logic [LW-1:0]     line_q, line_n;
  logic [LW-1:0]     ptr_q, ptr_n;
  logic [NLINES-1:0] mask_q, mask_n;
  logic [REG_W-1:0]  lpr_q;
  logic              txv_q;
  logic [LW-1:0]     txl_q;
  logic [CHAR_W-1:0] txb_q;
  logic              ctl_en;

  // hold-off after service accesses
  logic tick_go, hold_busy;
  sio_holdoff #(.HOLD_TICKS(HOLD_TICKS)) u_hold (
    .clk   (clk),
    .rst_n (rst_sync_n),
    .load  (rd_rxb | wr_tdr),
    .tick  (tick),
    .go    (tick_go),
    .busy  (hold_busy)
  );

  // mask as seen by a same-cycle tick
  assign mask_n = wr_txm ? bus_wdata[NLINES-1:0] : mask_q;

  logic          hit;
  logic [LW-1:0] hit_line;
  sio_line_pick #(.NLINES(NLINES)) u_pick (
    .ptr   (ptr_q),
    .en    (mask_n),
    .found (hit),
    .pick  (hit_line)
  );

  // next state: access first, then tick
  always_comb begin
    ctl_n  = ctl_q;
    line_n = line_q;
    ptr_n  = ptr_q;
    if (bus_sel) ctl_n.clr = 1'b0;
    if (wr_ctl) begin
      ctl_n.txie  = bus_wdata[B_TXIE];
      ctl_n.rxie  = bus_wdata[B_RXIE];
      ctl_n.scan  = bus_wdata[B_SCAN];
      ctl_n.clr   = bus_wdata[B_CLR];
      ctl_n.maint = bus_wdata[B_MAINT];
      if (!bus_wdata[B_SCAN]) begin
        ctl_n.trdy  = 1'b0;
        ctl_n.rdone = 1'b0;
      end
    end
    if (rd_rxb) ctl_n.rdone = 1'b0;
    if (wr_txm) ctl_n.trdy  = 1'b0;
    if (wr_tdr) ctl_n.trdy  = 1'b0;
    if (tick_go) begin
      ctl_n.rdone = 1'b0;
      if (ctl_n.scan && !ctl_n.trdy && hit) begin
        ctl_n.trdy = 1'b1;
        line_n     = hit_line;
        ptr_n      = hit_line;
      end else begin
        ctl_n.rdone = rxq_nonempty & ctl_n.scan;
      end
    end
    ctl_en = bus_sel | tick_go;
  end

  always_ff @(posedge clk or negedge rst_sync_n) begin
    if (!rst_sync_n) begin
      ctl_q  <= '{trdy: 1'b1, scan: 1'b1, default: 1'b0};
      line_q <= '0;
      ptr_q  <= '0;
    end else if (ctl_en) begin
      ctl_q  <= ctl_n;
      line_q <= line_n;
      ptr_q  <= ptr_n;
    end
  end

  always_ff @(posedge clk or negedge rst_sync_n) begin
    if (!rst_sync_n)  mask_q <= '0;
    else if (wr_txm)  mask_q <= mask_n;
  end

  always_ff @(posedge clk or negedge rst_sync_n) begin
    if (!rst_sync_n)  lpr_q <= '0;
    else if (wr_lpr)  lpr_q <= bus_wdata;
  end

  always_ff @(posedge clk or negedge rst_sync_n) begin
    if (!rst_sync_n) txv_q <= 1'b0;
    else             txv_q <= wr_tdr;
  end

  always_ff @(posedge clk or negedge rst_sync_n) begin
    if (!rst_sync_n) begin
      txl_q <= '0;
      txb_q <= '0;
    end else if (wr_tdr) begin
      txl_q <= line_q;
      txb_q <= bus_wdata[CHAR_W-1:0];
    end
  end

  // status word for reads (clear bit never visible)
  logic [REG_W-1:0] ctl_word;
  always_comb begin
    ctl_word                   = '0;
    ctl_word[B_TRDY]           = ctl_q.trdy;
    ctl_word[B_TXIE]           = ctl_q.txie;
    ctl_word[B_LINE_LO +: LW]  = line_q;
    ctl_word[B_RDONE]          = ctl_q.rdone;
    ctl_word[B_RXIE]           = ctl_q.rxie;
    ctl_word[B_SCAN]           = ctl_q.scan;
    ctl_word[B_MAINT]          = ctl_q.maint;
  end

  sio_rd_mux #(.NLINES(NLINES)) u_rd (
    .slot         (slot),
    .ctl_word     (ctl_word),
    .tx_mask      (mask_q),
    .rxq_nonempty (rxq_nonempty),
    .rxq_char     (rxq_char),
    .rxq_line     (rxq_line),
    .modem_stat   (modem_stat),
    .rdata        (bus_rdata)
  );

  assign rxq_pop    = rd_rxb & rxq_nonempty;
  assign line_param = lpr_q;
  assign tx_valid   = txv_q;
  assign tx_line    = txl_q;
  assign tx_byte    = txb_q;
  assign irq        = (ctl_q.trdy & ctl_q.txie) | (ctl_q.rdone & ctl_q.rxie);
endmodule

// File: rtl/sio_tx_scan_chk.sv
module sio_tx_scan_chk #(
  parameter int NLINES = 4,
  localparam int LW = $clog2(NLINES)
) (
  input logic              clk,
  input logic              rst_n,
  input logic              tick,
  input logic              wr_ctl,
  input logic              wr_txm,
  input logic              wr_tdr,
  input logic              rd_rxb,
  input logic              wd_scan,
  input logic              trdy,
  input logic              rdone,
  input logic              scan,
  input logic              hold_busy,
  input logic [LW-1:0]     line,
  input logic [LW-1:0]     ptr,
  input logic [NLINES-1:0] mask
);
  p_scan_off_clears_r2: assert property (@(posedge clk) disable iff (!rst_n)
    wr_ctl && !wd_scan |=> !trdy && !rdone);

  p_hit_line_enabled_r3: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(trdy) |-> mask[line]);

  p_rdone_needs_scan_r4: assert property (@(posedge clk) disable iff (!rst_n)
    rdone |-> scan);

  p_mask_write_drops_trdy_r6: assert property (@(posedge clk) disable iff (!rst_n)
    wr_txm && !tick |=> !trdy);

  p_data_write_drops_trdy_r7: assert property (@(posedge clk) disable iff (!rst_n)
    wr_tdr |=> !trdy);

  p_rx_read_drops_rdone_r8: assert property (@(posedge clk) disable iff (!rst_n)
    rd_rxb |=> !rdone);

  p_hold_freezes_ptr_r9: assert property (@(posedge clk) disable iff (!rst_n)
    tick && hold_busy |=> $stable(ptr));
endmodule

bind sio_tx_scan sio_tx_scan_chk #(.NLINES(NLINES)) u_chk (
  .clk       (clk),
  .rst_n     (rst_sync_n),
  .tick      (tick),
  .wr_ctl    (wr_ctl),
  .wr_txm    (wr_txm),
  .wr_tdr    (wr_tdr),
  .rd_rxb    (rd_rxb),
  .wd_scan   (bus_wdata[5]),
  .trdy      (ctl_q.trdy),
  .rdone     (ctl_q.rdone),
  .scan      (ctl_q.scan),
  .hold_busy (hold_busy),
  .line      (line_q),
  .ptr       (ptr_q),
  .mask      (mask_q)
);

// File: tb/sim_sio_tx_scan.sv
module sim_sio_tx_scan;
  logic        clk = 1'b0;
  logic        rst_n;
  logic        tick, bus_sel, bus_wr;
  logic [4:0]  bus_addr;
  logic [15:0] bus_wdata, bus_rdata;
  logic        rxq_nonempty, rxq_pop;
  logic [7:0]  rxq_char;
  logic [1:0]  rxq_line;
  logic [15:0] modem_stat, line_param;
  logic        tx_valid, irq;
  logic [1:0]  tx_line;
  logic [7:0]  tx_byte;

  always #4 clk = ~clk;

  sio_tx_scan u0 (
    .clk(clk), .rst_n(rst_n), .tick(tick), .bus_sel(bus_sel), .bus_wr(bus_wr),
    .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
    .rxq_nonempty(rxq_nonempty), .rxq_char(rxq_char), .rxq_line(rxq_line),
    .rxq_pop(rxq_pop), .modem_stat(modem_stat), .line_param(line_param),
    .tx_valid(tx_valid), .tx_line(tx_line), .tx_byte(tx_byte), .irq(irq)
  );

  int n_chk = 0;
  int n_err = 0;
  bit done  = 0;

  // bench model
  logic m_trdy, m_txie, m_rdone, m_rxie, m_scan, m_maint;
  logic [1:0]  m_line, m_ptr;
  logic [3:0]  m_mask;
  logic [15:0] m_lpr;
  int          m_hold;
  logic        m_txv;
  logic [1:0]  m_txl;
  logic [7:0]  m_txb;

  localparam logic [1:0] S_CTL = 2'd0, S_RXB = 2'd1, S_TXM = 2'd2, S_MDM = 2'd3;

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_err++;
      $display("FAIL %s act=%h exp=%h", tag, act, exp);
    end
  endtask

  function automatic logic [15:0] ctl_exp();
    return {m_trdy, m_txie, 4'b0, m_line, m_rdone, m_rxie, m_scan, 1'b0, m_maint, 3'b0};
  endfunction

  task automatic step(input logic sel, input logic wr, input logic [1:0] s,
                      input logic [15:0] wd, input logic tk, input logic ne,
                      input logic [7:0] ch, input logic [1:0] ln,
                      input logic [15:0] mdm, input string tag);
    logic [15:0] e_rd;
    logic n_trdy, n_rdone, found;
    logic [1:0] n_line, n_ptr, cand;
    logic [3:0] n_mask;
    int heff;
    bit go;
    @(negedge clk);
    bus_sel = sel; bus_wr = wr; bus_addr = {s, 3'b000}; bus_wdata = wd;
    tick = tk; rxq_nonempty = ne; rxq_char = ch; rxq_line = ln; modem_stat = mdm;
    #1;
    if (sel && !wr) begin
      case (s)
        S_CTL: e_rd = ctl_exp();
        S_RXB: e_rd = ne ? {1'b1, 5'b0, ln, ch} : 16'h0;
        S_TXM: e_rd = {12'h0, m_mask};
        default: e_rd = mdm | 16'h0F00;
      endcase
      chk(tag, bus_rdata, e_rd);
    end
    chk("R8 pop", rxq_pop, sel && !wr && s == S_RXB && ne);
    // model: access then tick
    n_trdy = m_trdy; n_rdone = m_rdone; n_line = m_line; n_ptr = m_ptr; n_mask = m_mask;
    if (sel && wr && s == S_CTL) begin
      m_txie = wd[14]; m_rxie = wd[6]; m_scan = wd[5]; m_maint = wd[3];
      if (!wd[5]) begin n_trdy = 0; n_rdone = 0; end
    end
    if (sel && !wr && s == S_RXB) n_rdone = 0;
    if (sel && wr && s == S_TXM) begin n_mask = wd[3:0]; n_trdy = 0; end
    if (sel && wr && s == S_MDM) n_trdy = 0;
    heff = ((sel && !wr && s == S_RXB) || (sel && wr && s == S_MDM)) ? 4 : m_hold;
    go = 0;
    if (tk) begin
      if (heff != 0) heff--;
      else go = 1;
    end
    if (go) begin
      n_rdone = 0;
      found = 0;
      for (int k = 1; k <= 4; k++) begin
        cand = m_ptr + 2'(k);
        if (!found && n_mask[cand]) begin found = 1; n_line = cand; end
      end
      if (m_scan && !n_trdy && found) begin
        n_trdy = 1; n_ptr = n_line;
      end else begin
        n_line = m_line;
        n_rdone = ne & m_scan;
      end
    end
    m_txv = sel && wr && s == S_MDM;
    if (m_txv) begin m_txl = m_line; m_txb = wd[7:0]; end
    if (sel && wr && s == S_RXB) m_lpr = wd;
    @(posedge clk);
    #1;
    m_trdy = n_trdy; m_rdone = n_rdone; m_line = n_line; m_ptr = n_ptr;
    m_mask = n_mask; m_hold = heff;
    chk("R10 irq", irq, (m_trdy & m_txie) | (m_rdone & m_rxie));
    chk("R7 tx_valid", tx_valid, m_txv);
    if (m_txv) chk("R7 tx", {tx_line, tx_byte}, {m_txl, m_txb});
    chk("R12 line_param", line_param, m_lpr);
  endtask

  task automatic idle(input logic tk, input logic ne, input string tag);
    step(0, 0, S_CTL, 16'h0, tk, ne, 8'h0, 2'h0, 16'h0, tag);
  endtask

  task automatic summary();
    $display("  CHECKS %0d ERRORS %0d", n_chk, n_err);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      n_err++;
      $display("FAIL watchdog act=running exp=finished");
      summary();
      $finish;
    end
  end

  initial begin
    logic [15:0] wd;
    int r;
    void'($urandom(32'd20240607));
    rst_n = 0; tick = 0; bus_sel = 0; bus_wr = 0; bus_addr = '0; bus_wdata = '0;
    rxq_nonempty = 0; rxq_char = '0; rxq_line = '0; modem_stat = '0;
    m_trdy = 1; m_scan = 1; m_txie = 0; m_rdone = 0; m_rxie = 0; m_maint = 0;
    m_line = 0; m_ptr = 0; m_mask = 0; m_lpr = 0; m_hold = 0;
    m_txv = 0; m_txl = 0; m_txb = 0;
    repeat (4) @(posedge clk);
    @(negedge clk) rst_n = 1;
    repeat (3) idle(0, 0, "R1");

    // directed
    step(1, 0, S_CTL, 0, 0, 0, 0, 0, 0, "R1 ctl");
    step(1, 0, S_TXM, 0, 0, 0, 0, 0, 0, "R1 mask");
    step(1, 1, S_TXM, 16'h000A, 0, 0, 0, 0, 0, "R6");
    step(1, 0, S_TXM, 0, 0, 0, 0, 0, 0, "R6 readback");
    idle(1, 0, "R3");
    step(1, 0, S_CTL, 0, 0, 0, 0, 0, 0, "R3 hit line1");
    step(1, 1, S_MDM, 16'h775A, 0, 0, 0, 0, 0, "R7");
    repeat (4) idle(1, 1, "R9");
    step(1, 0, S_CTL, 0, 0, 0, 0, 0, 0, "R9 held");
    idle(1, 1, "R5");
    step(1, 0, S_CTL, 0, 0, 0, 0, 0, 0, "R5 hit line3 no rdone");
    step(1, 1, S_CTL, 16'h4078, 0, 0, 0, 0, 0, "R2");
    step(1, 0, S_CTL, 0, 0, 0, 0, 0, 0, "R2 clr reads 0");
    step(1, 1, S_TXM, 16'h0000, 0, 0, 0, 0, 0, "R6");
    idle(1, 1, "R4");
    step(1, 0, S_CTL, 0, 0, 0, 0, 0, 0, "R4 rdone");
    step(1, 0, S_RXB, 0, 0, 1, 8'h41, 2'd2, 0, "R8 rbuf");
    step(1, 0, S_RXB, 0, 0, 0, 8'h55, 2'd1, 0, "R8 empty");
    step(1, 0, S_MDM, 0, 0, 0, 0, 0, 16'h1234, "R11");
    step(1, 1, S_RXB, 16'hBEEF, 0, 0, 0, 0, 0, "R12");
    step(1, 1, S_CTL, 16'h0000, 1, 1, 0, 0, 0, "R2 scan off");
    step(1, 0, S_CTL, 0, 0, 0, 0, 0, 0, "R2 flags cleared");
    repeat (6) idle(1, 1, "R4");
    step(1, 0, S_CTL, 0, 0, 0, 0, 0, 0, "R4 no rdone without scan");

    // random mix with tick/access collisions
    for (int i = 0; i < 4000; i++) begin
      r  = $urandom_range(0, 99);
      wd = 16'($urandom);
      if (r < 25) begin
        idle($urandom_range(0, 2) == 0, $urandom_range(0, 1) == 1, "R3 rnd");
      end else if (r < 35) begin
        wd[5] = ($urandom_range(0, 9) != 0);
        step(1, 1, S_CTL, wd, $urandom_range(0, 2) == 0, $urandom_range(0, 1) == 1,
             0, 0, 0, "R2 rnd");
      end else if (r < 45) begin
        step(1, 1, S_TXM, wd, $urandom_range(0, 2) == 0, $urandom_range(0, 1) == 1,
             0, 0, 0, "R6 rnd");
      end else if (r < 53) begin
        step(1, 1, S_MDM, wd, $urandom_range(0, 2) == 0, $urandom_range(0, 1) == 1,
             0, 0, 0, "R7 rnd");
      end else if (r < 61) begin
        step(1, 0, S_RXB, 0, $urandom_range(0, 2) == 0, $urandom_range(0, 1) == 1,
             8'($urandom), 2'($urandom), 0, "R8 rnd");
      end else if (r < 65) begin
        step(1, 1, S_RXB, wd, $urandom_range(0, 2) == 0, 0, 0, 0, 0, "R12 rnd");
      end else if (r < 88) begin
        step(1, 0, S_CTL, 0, $urandom_range(0, 2) == 0, $urandom_range(0, 1) == 1,
             0, 0, 0, "R3 rnd ctl");
      end else if (r < 94) begin
        step(1, 0, S_TXM, 0, $urandom_range(0, 2) == 0, 0, 0, 0, 0, "R6 rnd");
      end else begin
        step(1, 0, S_MDM, 0, $urandom_range(0, 2) == 0, 0, 0, 0, wd, "R11 rnd");
      end
    end

    done = 1;
    summary();
    $finish;
  end
endmodule